// File: doc/BRIEF.md
# Virtual-Impedance LCL Trajectory Filter

This block turns each new sample of a bus voltage and a reference voltage into the four target waveforms that an H-bridge controller should follow through its LCL output filter. The targets are the output current, the filter capacitor voltage, the bridge-side inductor current and the bridge voltage. The output current comes from a virtual admittance law that acts on the error e = vbus - vref. Firmware loads the law's gains. It sets a nonzero integral gain for a capacitive admittance or a nonzero derivative gain for an inductive one, and a proportional gain for the conductance. The filter quantities then follow from the output current, stage by stage from the bus side toward the bridge, using backward differences.

All gains and filter constants are unsigned fixed-point values with FRAC fractional bits. Each is already scaled by the sample period, so no divide happens at run time. Every product is shifted right arithmetically by FRAC bits, which rounds toward minus infinity. The integral accumulator and every output are clamped to symmetric limits that firmware programs. A clear input returns the filter to its start-up state.

Top module: `vtf_traj`

## Requirements
- R1: While `rst` or `clr` is high, all four outputs and `out_vld` go to zero on the next edge. The accumulator and all previous-sample registers are also zeroed. `clr` wins over a simultaneous `smp_vld`.
- R2: A sample taken with `smp_vld` high appears on the outputs one edge later, with `out_vld` high for exactly that one cycle. Without a sample, the outputs hold their values.
- R3: `io = sat(((kp*e)>>>FRAC) + acc + ((kd_h*(e - e_prev))>>>FRAC), out_lim)`, where `e_prev` is the error of the previous sample (zero after a clear) and `>>>` rounds toward minus infinity.
- R4: The integral term uses only earlier samples. The accumulator adds `(ki_h*e)>>>FRAC` after the current `io` has been formed, so the first sample after a clear sees an accumulator of zero.
- R5: The accumulator is clamped to the range [-acc_lim, +acc_lim].
- R6: `vc = sat(vbus - ((lcon_h*(io - io_prev))>>>FRAC), out_lim)`.
- R7: `il = sat(((c_h*(vc - vc_prev))>>>FRAC) - io, out_lim)`.
- R8: `vh = sat(((l_h*(il - il_prev))>>>FRAC) + vc, out_lim)`.
- R9: Every output is clamped to [-out_lim, +out_lim]. The previous-sample registers keep the clamped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous state clear |
| smp_vld | input | 1 | New sample present on vbus/vref |
| vbus | input | DW | Bus voltage sample, signed |
| vref | input | DW | Reference voltage sample, signed |
| kp | input | GW | Proportional gain, unsigned Q.FRAC |
| ki_h | input | GW | Integral gain times sample period |
| kd_h | input | GW | Derivative gain over sample period |
| lcon_h | input | GW | Grid-side inductance over sample period |
| c_h | input | GW | Capacitance over sample period |
| l_h | input | GW | Bridge-side inductance over sample period |
| acc_lim | input | AW-1 | Accumulator magnitude limit |
| out_lim | input | DW-1 | Output magnitude limit |
| io_o | output | DW | Output current target |
| vc_o | output | DW | Capacitor voltage target |
| il_o | output | DW | Inductor current target |
| vh_o | output | DW | Bridge voltage target |
| out_vld | output | 1 | Outputs updated this cycle |

## Verification
The bench first drives the integral path after a clear. A design that added the current error before forming the output current would give a nonzero first value, so the integral would run one sample early. It then drives the accumulator into its limit, sends samples that push each output past its limit in both directions, and checks an odd negative product. The odd product shows whether the design rounds toward minus infinity rather than truncating toward zero. The bench also checks the derivative chain after a clear, where a stale previous-sample register would show up as a wrong first difference. Finally it asserts a clear in the same cycle as a sample; a design that let the sample win would leave nonzero outputs.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    localparam int WIDE = 48;

    typedef logic signed [WIDE-1:0] wide_t;

    typedef enum logic {
        SGN_ADD = 1'b0,
        SGN_SUB = 1'b1
    } sgn_e;

    function automatic wide_t sat(wide_t x, wide_t lim);
        if (x > lim)
            return lim;
        else if (x < -lim)
            return -lim;
        return x;
    endfunction

    function automatic wide_t mulsh(wide_t g, wide_t x, int unsigned f);
        wide_t p;
        p = g * x;
        return p >>> f;
    endfunction

endpackage

// File: rtl/vtf_law.sv
module vtf_law
    import vtf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int AW   = 20,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] vbus,
    input  logic signed [DW-1:0] vref,
    input  logic        [GW-1:0] kp,
    input  logic        [GW-1:0] ki_h,
    input  logic        [GW-1:0] kd_h,
    input  logic        [AW-2:0] acc_lim,
    input  logic        [DW-2:0] out_lim,
    output logic signed [DW-1:0] io
);

    logic signed [DW:0]   e_q;
    logic signed [AW-1:0] acc_q;
    wide_t e_w, p_w, d_w, sum_w, acc_nx;

    always_comb begin
        e_w    = wide_t'(vbus) - wide_t'(vref);
        p_w    = mulsh(wide_t'(kp), e_w, FRAC);
        d_w    = mulsh(wide_t'(kd_h), e_w - wide_t'(e_q), FRAC);
        sum_w  = p_w + wide_t'(acc_q) + d_w;
        io     = DW'(sat(sum_w, wide_t'(out_lim)));
        // integral uses only earlier samples; updated after io is formed
        acc_nx = sat(wide_t'(acc_q) + mulsh(wide_t'(ki_h), e_w, FRAC),
                     wide_t'(acc_lim));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            e_q   <= '0;
            acc_q <= '0;
        end else if (en) begin
            e_q   <= (DW+1)'(e_w);
            acc_q <= AW'(acc_nx);
        end
    end

endmodule

// File: rtl/vtf_bdstage.sv
module vtf_bdstage
    import vtf_pkg::*;
#(
    parameter int   DW    = 16,
    parameter int   GW    = 16,
    parameter int   FRAC  = 8,
    parameter sgn_e D_SGN = SGN_ADD,
    parameter sgn_e B_SGN = SGN_ADD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] b,
    input  logic        [GW-1:0] k,
    input  logic        [DW-2:0] lim,
    output logic signed [DW-1:0] y
);

    logic signed [DW-1:0] x_q;
    wide_t dk_w, t_w;

    always_comb begin
        dk_w = mulsh(wide_t'(k), wide_t'(x) - wide_t'(x_q), FRAC);
        t_w  = (D_SGN == SGN_SUB) ? -dk_w : dk_w;
        t_w  = (B_SGN == SGN_SUB) ? (t_w - wide_t'(b)) : (t_w + wide_t'(b));
        y    = DW'(sat(t_w, wide_t'(lim)));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            x_q <= '0;
        else if (en)
            x_q <= x;
    end

endmodule

// File: rtl/vtf_traj.sv
module vtf_traj
    import vtf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int AW   = 20,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] vbus,
    input  logic signed [DW-1:0] vref,
    input  logic        [GW-1:0] kp,
    input  logic        [GW-1:0] ki_h,
    input  logic        [GW-1:0] kd_h,
    input  logic        [GW-1:0] lcon_h,
    input  logic        [GW-1:0] c_h,
    input  logic        [GW-1:0] l_h,
    input  logic        [AW-2:0] acc_lim,
    input  logic        [DW-2:0] out_lim,
    output logic signed [DW-1:0] io_o,
    output logic signed [DW-1:0] vc_o,
    output logic signed [DW-1:0] il_o,
    output logic signed [DW-1:0] vh_o,
    output logic                 out_vld
);

    logic signed [DW-1:0] io_n, vc_n, il_n, vh_n;

    vtf_law #(.DW(DW), .GW(GW), .AW(AW), .FRAC(FRAC)) u_law (
        .clk(clk), .rst(rst), .clr(clr), .en(smp_vld),
        .vbus(vbus), .vref(vref), .kp(kp), .ki_h(ki_h), .kd_h(kd_h),
        .acc_lim(acc_lim), .out_lim(out_lim), .io(io_n)
    );

    // capacitor: vbus minus grid-inductor drop
    vtf_bdstage #(.DW(DW), .GW(GW), .FRAC(FRAC),
                  .D_SGN(SGN_SUB), .B_SGN(SGN_ADD)) u_cap (
        .clk(clk), .rst(rst), .clr(clr), .en(smp_vld),
        .x(io_n), .b(vbus), .k(lcon_h), .lim(out_lim), .y(vc_n)
    );

    // inductor: capacitor charging current minus output current
    vtf_bdstage #(.DW(DW), .GW(GW), .FRAC(FRAC),
                  .D_SGN(SGN_ADD), .B_SGN(SGN_SUB)) u_ind (
        .clk(clk), .rst(rst), .clr(clr), .en(smp_vld),
        .x(vc_n), .b(io_n), .k(c_h), .lim(out_lim), .y(il_n)
    );

    // bridge: inductor drop plus capacitor voltage
    vtf_bdstage #(.DW(DW), .GW(GW), .FRAC(FRAC),
                  .D_SGN(SGN_ADD), .B_SGN(SGN_ADD)) u_brg (
        .clk(clk), .rst(rst), .clr(clr), .en(smp_vld),
        .x(il_n), .b(vc_n), .k(l_h), .lim(out_lim), .y(vh_n)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            io_o    <= '0;
            vc_o    <= '0;
            il_o    <= '0;
            vh_o    <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                io_o <= io_n;
                vc_o <= vc_n;
                il_o <= il_n;
                vh_o <= vh_n;
            end
        end
    end

endmodule

// File: rtl/vtf_traj_chk.sv
module vtf_traj_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr,
    input logic                 smp_vld,
    input logic        [DW-2:0] out_lim,
    input logic signed [DW-1:0] io_o,
    input logic signed [DW-1:0] vc_o,
    input logic signed [DW-1:0] il_o,
    input logic signed [DW-1:0] vh_o,
    input logic                 out_vld
);

    logic signed [DW-1:0] lim_s;
    assign lim_s = $signed({1'b0, out_lim});

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!out_vld && io_o == 0 && vc_o == 0 && il_o == 0 && vh_o == 0));

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !clr) |=> out_vld);

    a_r2_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !out_vld);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !clr) |=> ($stable(io_o) && $stable(vc_o) && $stable(il_o) && $stable(vh_o)));

    a_r9_io_range: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (io_o <= $past(lim_s) && io_o >= -$past(lim_s)));

    a_r9_vh_range: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (vh_o <= $past(lim_s) && vh_o >= -$past(lim_s)
                     && vc_o <= $past(lim_s) && vc_o >= -$past(lim_s)
                     && il_o <= $past(lim_s) && il_o >= -$past(lim_s)));

endmodule

bind vtf_traj vtf_traj_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .out_lim(out_lim),
    .io_o(io_o), .vc_o(vc_o), .il_o(il_o), .vh_o(vh_o), .out_vld(out_vld)
);

// File: tb/sim_vtf_traj.sv
module sim_vtf_traj;

    localparam int DW = 16, GW = 16, AW = 20, FRAC = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, clr, smp_vld;
    logic signed [DW-1:0] vbus, vref;
    logic [GW-1:0] kp, ki_h, kd_h, lcon_h, c_h, l_h;
    logic [AW-2:0] acc_lim;
    logic [DW-2:0] out_lim;
    logic signed [DW-1:0] io_o, vc_o, il_o, vh_o;
    logic out_vld;

    vtf_traj #(.DW(DW), .GW(GW), .AW(AW), .FRAC(FRAC)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam int NV = 16;
    localparam int TV_BUS [0:NV-1] = '{ 120, 300, -50, -400, 700, 0, 33, -1,
                                        900, -900, 250, 251, -7, 64, -128, 5 };
    localparam int TV_REF [0:NV-1] = '{ 100, 0, 50, -300, 0, 0, -33, 2,
                                        -100, 100, 250, 0, 7, 60, -100, -5 };

    // bench model state
    longint m_acc, m_ep, m_io, m_vc, m_il;
    longint e_io, e_vc, e_il, e_vh;

    function automatic longint sat_m(longint x, longint l);
        if (x > l) return l;
        if (x < -l) return -l;
        return x;
    endfunction

    function automatic longint msh(longint g, longint x);
        return (g * x) >>> FRAC;
    endfunction

    task automatic model_clear();
        m_acc = 0; m_ep = 0; m_io = 0; m_vc = 0; m_il = 0;
    endtask

    task automatic model_step(longint vb, longint vr);
        longint e, ol;
        ol   = longint'(out_lim);
        e    = vb - vr;
        e_io = sat_m(msh(kp, e) + m_acc + msh(kd_h, e - m_ep), ol);
        e_vc = sat_m(vb - msh(lcon_h, e_io - m_io), ol);
        e_il = sat_m(msh(c_h, e_vc - m_vc) - e_io, ol);
        e_vh = sat_m(msh(l_h, e_il - m_il) + e_vc, ol);
        m_acc = sat_m(m_acc + msh(ki_h, e), longint'(acc_lim));
        m_ep = e; m_io = e_io; m_vc = e_vc; m_il = e_il;
    endtask

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_gains(int p, int i, int d, int lc, int c, int l, int al, int ol);
        @(negedge clk);
        kp = GW'(p); ki_h = GW'(i); kd_h = GW'(d);
        lcon_h = GW'(lc); c_h = GW'(c); l_h = GW'(l);
        acc_lim = (AW-1)'(al); out_lim = (DW-1)'(ol);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        chk("R1 clr io", io_o, 0);
        chk("R1 clr vh", vh_o, 0);
        chk("R1 clr out_vld", out_vld, 0);
    endtask

    task automatic sample(int vb, int vr);
        @(negedge clk);
        vbus = DW'(vb); vref = DW'(vr); smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic expect4(string req, int io, int vc, int il, int vh);
        chk({req, " io"}, io_o, io);
        chk({req, " vc"}, vc_o, vc);
        chk({req, " il"}, il_o, il);
        chk({req, " vh"}, vh_o, vh);
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; smp_vld = 1'b0; vbus = '0; vref = '0;
        kp = '0; ki_h = '0; kd_h = '0; lcon_h = '0; c_h = '0; l_h = '0;
        acc_lim = '0; out_lim = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 reset io", io_o, 0);
        chk("R1 reset vc", vc_o, 0);
        chk("R1 reset out_vld", out_vld, 0);

        // table walk, PD law with the full chain (R3 R6 R7 R8), then PI law (R4)
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 0) set_gains(192, 0, 64, 32, 48, 24, 200000, 8000);
            else           set_gains(96, 40, 0, 20, 70, 12, 3000, 6000);
            do_clear();
            for (int v = 0; v < NV; v++) begin
                sample(TV_BUS[v], TV_REF[v]);
                model_step(TV_BUS[v], TV_REF[v]);
                chk("R2 out_vld", out_vld, 1);
                chk("R3 io", io_o, e_io);
                chk("R6 vc", vc_o, e_vc);
                chk("R7 il", il_o, e_il);
                chk("R8 vh", vh_o, e_vh);
            end
        end

        // R2: single-cycle valid pulse and hold
        @(negedge clk);
        chk("R2 vld pulse", out_vld, 0);
        repeat (3) @(negedge clk);
        chk("R2 hold io", io_o, e_io);
        chk("R2 hold vh", vh_o, e_vh);

        // R3 proportional only
        set_gains(256, 0, 0, 0, 0, 0, 1000, 10000);
        do_clear();
        sample(100, 40);
        expect4("R3 prop", 60, 100, -60, 100);
        // R3 floor rounding: 128*(-3)=-384, >>>8 = -2
        set_gains(128, 0, 0, 0, 0, 0, 1000, 10000);
        do_clear();
        sample(-3, 0);
        chk("R3 floor io", io_o, -2);

        // R3 derivative
        set_gains(0, 0, 256, 0, 0, 0, 1000, 10000);
        do_clear();
        sample(0, 0);   chk("R3 pd io", io_o, 0);
        sample(20, 0);  chk("R3 pd io", io_o, 20);
        sample(20, 0);  chk("R3 pd io", io_o, 0);
        sample(-10, 0); chk("R3 pd io", io_o, -30);

        // R4 integral excludes current sample
        set_gains(0, 128, 0, 0, 0, 0, 1000, 10000);
        do_clear();
        sample(10, 0); expect4("R4 pi first", 0, 10, 0, 10);
        sample(10, 0); chk("R4 pi io", io_o, 5);
        sample(10, 0); chk("R4 pi io", io_o, 10);

        // R5 accumulator limit
        set_gains(0, 256, 0, 0, 0, 0, 250, 10000);
        do_clear();
        sample(100, 0); chk("R5 acc io", io_o, 0);
        sample(100, 0); chk("R5 acc io", io_o, 100);
        sample(100, 0); chk("R5 acc io", io_o, 200);
        sample(100, 0); chk("R5 acc io", io_o, 250);
        sample(100, 0); chk("R5 acc io", io_o, 250);

        // R6 grid-inductor drop
        set_gains(256, 0, 0, 256, 0, 0, 1000, 10000);
        do_clear();
        sample(50, 0); expect4("R6 first", 50, 0, -50, 0);
        sample(50, 0); expect4("R6 second", 50, 50, -50, 50);

        // R7 capacitor current
        set_gains(256, 0, 0, 0, 512, 0, 1000, 10000);
        do_clear();
        sample(30, 0); expect4("R7 first", 30, 30, 30, 30);
        sample(30, 0); chk("R7 il", il_o, -30);

        // R8 bridge voltage
        set_gains(0, 0, 0, 0, 256, 256, 1000, 10000);
        do_clear();
        sample(40, 0); expect4("R8 first", 0, 40, 40, 80);
        sample(40, 0); expect4("R8 second", 0, 40, 0, 0);

        // R9 output saturation both directions
        set_gains(256, 0, 0, 0, 0, 0, 1000, 300);
        do_clear();
        sample(1000, 0);  expect4("R9 pos", 300, 300, -300, 300);
        sample(-1000, 0); expect4("R9 neg", -300, -300, 300, -300);

        // R1 clear wins over sample, state zeroed
        set_gains(0, 128, 0, 0, 0, 0, 1000, 10000);
        do_clear();
        sample(10, 0);
        sample(10, 0);
        @(negedge clk);
        vbus = DW'(10); smp_vld = 1'b1; clr = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; clr = 1'b0;
        chk("R1 clr priority io", io_o, 0);
        chk("R1 clr priority vld", out_vld, 0);
        chk("R1 clr priority vc", vc_o, 0);
        sample(10, 0);
        chk("R1 acc cleared io", io_o, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule